// File: doc/BRIEF.md
# Microinstruction Sequence-Field Decoder

This block holds a control store of 128 microinstructions, each 25 bits wide, and reads the word addressed by the micro program counter input combinationally in the same cycle. It splits that word into its ALU, to-bus, from-bus, sequence and micro-address fields. It also turns the 4-bit sequence field, together with the five processor status flags (Z, N, C, O, L), into a 3-bit next-address command and a jump target for the micro program counter.

The ALU and bus fields are only passed out; acting on them is left to neighbouring logic. A halt word raises a registered halt indication one cycle after it is addressed. A synchronous write port fills the store. It is meant for test and initial loading.

Top module: `useq_decoder`

## Requirements
- R1: A word written through the write port (wr_en high at a rising edge) is the word seen on the field outputs whenever ctl_pc equals that address from the next cycle on; a later write to the same address replaces it.
- R2: Field positions within the word: ALU field bits 24..21, to-bus field bits 20..18, from-bus field bits 17..15, sequence field bits 10..7, micro-address field bits 6..0; bits 14..11 are not decoded. The fields follow ctl_pc in the same cycle.
- R3: Fixed commands: sequence 0000 gives command 000 (increment), 0001 gives 001 (load from first mapping table), 0010 gives 010 (load from second mapping table), 0011 gives 011 (clear counter to zero), 0111 gives 101 (return from subroutine).
- R4: Sequence 0101 gives command 100 (jump) and sequence 0110 gives command 110 (call); the jump target output always equals the micro-address field.
- R5: Sequences 1000, 1001, 1010, 1011 and 1100 give command 100 when flag Z, N, C, O or L respectively is 1, and command 000 otherwise; the other flags have no effect.
- R6: Sequences 0100, 1101 and 1110 give command 100 when flag Z, C or O respectively is 0, and command 000 otherwise; the other flags have no effect.
- R7: Sequence 1111 gives command 011 at once; the halt output is 1 in the cycle after a rising edge at which the addressed word's sequence field was 1111, and 0 after an edge where it was anything else.
- R8: An active-low reset clears the halt output at once, and command 111 is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the halt register |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 7 | Store write address |
| wr_data | input | 25 | Store write data |
| ctl_pc | input | 7 | Micro program counter, selects the word read |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| flag_o | input | 1 | Overflow flag |
| flag_l | input | 1 | Loop-count-zero flag |
| alu_fld | output | 4 | ALU field |
| tobus_fld | output | 3 | To-bus field |
| frombus_fld | output | 3 | From-bus field |
| seq_fld | output | 4 | Sequence field |
| uaddr_fld | output | 7 | Micro-address field |
| next_cmd | output | 3 | Next-address command |
| jump_tgt | output | 7 | Jump or call target |
| halt | output | 1 | Registered halt indication |

## Verification
The bench drives each conditional code with only its own flag set and again with every other flag set and its own flag clear, so a decoder that tests the wrong flag or the wrong polarity issues the wrong command in one of the two patterns. It fills the unused bits 14..11 with ones, so a field cut one bit off shows stray ones. It checks halt in the fetch cycle and again after the edge; a combinational halt shows up a cycle early and a sticky one fails to drop. It also overwrites a stored word, which catches a store that ignores later writes.

// File: rtl/useq_decoder.sv
module useq_decoder #(
  parameter int DEPTH  = 128,
  parameter int WORD_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [6:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [6:0]        ctl_pc,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_c,
  input  logic              flag_o,
  input  logic              flag_l,
  output logic [3:0]        alu_fld,
  output logic [2:0]        tobus_fld,
  output logic [2:0]        frombus_fld,
  output logic [3:0]        seq_fld,
  output logic [6:0]        uaddr_fld,
  output logic [2:0]        next_cmd,
  output logic [6:0]        jump_tgt,
  output logic              halt
);

  localparam logic [2:0] CMD_INC  = 3'b000;
  localparam logic [2:0] CMD_K1   = 3'b001;
  localparam logic [2:0] CMD_K2   = 3'b010;
  localparam logic [2:0] CMD_ZERO = 3'b011;
  localparam logic [2:0] CMD_JMP  = 3'b100;
  localparam logic [2:0] CMD_RET  = 3'b101;
  localparam logic [2:0] CMD_CALL = 3'b110;

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk)
    if (wr_en) store[wr_addr] <= wr_data;

  assign word        = store[ctl_pc];
  assign alu_fld     = word[24:21];
  assign tobus_fld   = word[20:18];
  assign frombus_fld = word[17:15];
  assign seq_fld     = word[10:7];
  assign uaddr_fld   = word[6:0];
  assign jump_tgt    = uaddr_fld;

  function automatic logic [2:0] cond(input logic flag, input logic want);
    return (flag == want) ? CMD_JMP : CMD_INC;
  endfunction

  always_comb begin
    unique case (seq_fld)
      4'b0000: next_cmd = CMD_INC;
      4'b0001: next_cmd = CMD_K1;
      4'b0010: next_cmd = CMD_K2;
      4'b0011: next_cmd = CMD_ZERO;
      4'b0100: next_cmd = cond(flag_z, 1'b0);
      4'b0101: next_cmd = CMD_JMP;
      4'b0110: next_cmd = CMD_CALL;
      4'b0111: next_cmd = CMD_RET;
      4'b1000: next_cmd = cond(flag_z, 1'b1);
      4'b1001: next_cmd = cond(flag_n, 1'b1);
      4'b1010: next_cmd = cond(flag_c, 1'b1);
      4'b1011: next_cmd = cond(flag_o, 1'b1);
      4'b1100: next_cmd = cond(flag_l, 1'b1);
      4'b1101: next_cmd = cond(flag_c, 1'b0);
      4'b1110: next_cmd = cond(flag_o, 1'b0);
      default: next_cmd = CMD_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) halt <= 1'b0;
    else        halt <= (seq_fld == 4'b1111);

  p_store_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> store[$past(wr_addr)] == $past(wr_data));

  p_halt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_fld == 4'b1111) |=> halt);

  p_halt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_fld != 4'b1111) |=> !halt);

  p_no_cmd7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    next_cmd != 3'b111);

endmodule

// File: tb/useq_decoder_tb_top.sv
module useq_decoder_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [6:0] wr_addr = 0, ctl_pc = 0;
  logic [24:0] wr_data = 0;
  logic flag_z = 0, flag_n = 0, flag_c = 0, flag_o = 0, flag_l = 0;
  logic [3:0] alu_fld, seq_fld;
  logic [2:0] tobus_fld, frombus_fld, next_cmd;
  logic [6:0] uaddr_fld, jump_tgt;
  logic halt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  useq_decoder dut_i (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .ctl_pc,
    .flag_z, .flag_n, .flag_c, .flag_o, .flag_l, .alu_fld, .tobus_fld,
    .frombus_fld, .seq_fld, .uaddr_fld, .next_cmd, .jump_tgt, .halt);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] mk(logic [3:0] a, logic [2:0] t, logic [2:0] f,
                                     logic [3:0] s, logic [6:0] u);
    return {a, t, f, 4'hF, s, u};
  endfunction

  task automatic load(logic [6:0] a, logic [24:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_flags(logic [4:0] f);
    {flag_l, flag_o, flag_c, flag_n, flag_z} = f;
  endtask

  task automatic cmd_at(string req, logic [6:0] a, logic [4:0] f, int exp);
    @(negedge clk); ctl_pc = a; set_flags(f); #2;
    check(req, next_cmd, exp);
  endtask

  task automatic t_reset;
    check("R8 reset halt", halt, 0);
  endtask

  task automatic t_fields;
    load(7'd5, mk(4'hA, 3'd5, 3'd3, 4'b0000, 7'h2C));
    @(negedge clk); ctl_pc = 5; #2;
    check("R2 alu", alu_fld, 4'hA);
    check("R2 tobus", tobus_fld, 5);
    check("R2 frombus", frombus_fld, 3);
    check("R2 seq", seq_fld, 0);
    check("R2 uaddr", uaddr_fld, 7'h2C);
    load(7'd5, mk(4'h3, 3'd2, 3'd6, 4'b0000, 7'h51));
    @(negedge clk); ctl_pc = 5; #2;
    check("R1 rewrite alu", alu_fld, 4'h3);
    check("R1 rewrite uaddr", uaddr_fld, 7'h51);
    check("R1 rewrite frombus", frombus_fld, 6);
  endtask

  task automatic t_fixed;
    load(7'd10, mk(0, 0, 0, 4'b0000, 7'h11));
    load(7'd11, mk(0, 0, 0, 4'b0001, 7'h11));
    load(7'd12, mk(0, 0, 0, 4'b0010, 7'h11));
    load(7'd13, mk(0, 0, 0, 4'b0011, 7'h11));
    load(7'd14, mk(0, 0, 0, 4'b0111, 7'h11));
    cmd_at("R3 seq0000", 10, 5'h1F, 0);
    cmd_at("R3 seq0001", 11, 5'h00, 1);
    cmd_at("R3 seq0010", 12, 5'h1F, 2);
    cmd_at("R3 seq0011", 13, 5'h00, 3);
    cmd_at("R3 seq0111", 14, 5'h1F, 5);
  endtask

  task automatic t_jump;
    load(7'd15, mk(0, 0, 0, 4'b0101, 7'h33));
    load(7'd16, mk(0, 0, 0, 4'b0110, 7'h4E));
    cmd_at("R4 jump", 15, 5'h00, 4);
    check("R4 jump target", jump_tgt, 7'h33);
    cmd_at("R4 call", 16, 5'h1F, 6);
    check("R4 call target", jump_tgt, 7'h4E);
  endtask

  task automatic t_cond_set;
    for (int i = 0; i < 5; i++) begin
      load(7'(30 + i), mk(0, 0, 0, 4'(8 + i), 7'(i + 1)));
      cmd_at("R5 own flag set", 7'(30 + i), 5'(1 << i), 4);
      cmd_at("R5 own flag clear", 7'(30 + i), 5'h1F ^ 5'(1 << i), 0);
    end
  endtask

  task automatic t_cond_clr;
    logic [3:0] codes [3] = '{4'b0100, 4'b1101, 4'b1110};
    int bits [3] = '{0, 2, 3};
    for (int i = 0; i < 3; i++) begin
      load(7'(40 + i), mk(0, 0, 0, codes[i], 7'h7F));
      cmd_at("R6 own flag clear", 7'(40 + i), 5'h1F ^ 5'(1 << bits[i]), 4);
      cmd_at("R6 own flag set", 7'(40 + i), 5'(1 << bits[i]), 0);
    end
  endtask

  task automatic t_halt;
    load(7'd20, mk(0, 0, 0, 4'b1111, 7'h05));
    cmd_at("R7 halt command", 20, 5'h00, 3);
    check("R7 halt not yet", halt, 0);
    @(negedge clk); check("R7 halt raised", halt, 1);
    ctl_pc = 10;
    @(negedge clk); check("R7 halt dropped", halt, 0);
    ctl_pc = 20;
    @(negedge clk); check("R7 halt again", halt, 1);
    rst_n = 0; #2;
    check("R8 reset clears halt", halt, 0);
    @(negedge clk); ctl_pc = 10;
    @(negedge clk); rst_n = 1;
    @(negedge clk); check("R8 halt stays low", halt, 0);
  endtask

  initial begin
    load(7'd0, mk(0, 0, 0, 4'b0000, 7'h00));
    t_reset();
    @(negedge clk); rst_n = 1;
    t_fields();
    t_fixed();
    t_jump();
    t_cond_set();
    t_cond_clr();
    t_halt();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule